// File: doc/BRIEF.md
# MMC Boot-Partition Read Sequencer

This host-side sequencer reads boot data from an MMC device without going through the normal card identification flow. A single `start_i` pulse latches the block count, the bus width, the acknowledge enable and a wait limit. The controller then pulls the CMD line low, and it keeps that line low for the whole boot read. If acknowledge is enabled, it first checks the device's acknowledge token on DAT0. After that it collects the programmed number of 512-byte blocks from the data lines.

Each block begins with a start bit. Payload bits arrive MSB first on one, four or eight lines and are packed into bytes. Each byte is presented for one cycle with a valid strobe, in the order it was received. The CRC16 field and the end bit that follow each block are skipped without being checked. When the last block is complete, CMD is released high and a done flag is raised. If the acknowledge is wrong or does not arrive, an acknowledge error is flagged and the boot is aborted. If a data start bit does not arrive within the wait limit, a data timeout is flagged and the boot is aborted.

Top module: `mmc_boot_rd`

## Requirements
- R1: After reset, `cmd_o` is 1 and `byte_vld_o`, `done_o`, `ack_err_o` and `data_to_err_o` are all 0.
- R2: In the cycle after a `start_i` pulse with a non-zero block count, `cmd_o` goes to 0, and `done_o` and both error flags are cleared. `cmd_o` stays 0 until the boot read completes or aborts.
- R3: With `ack_en_i`=1, the controller waits for a 0 on DAT0, which is the token start. It then requires 0, 1, 0 and then an end bit of 1 on DAT0 in the next four cycles before it waits for data.
- R4: If any of those four acknowledge bits differs from the expected value, `ack_err_o` is set, `cmd_o` returns to 1 and no bytes are emitted.
- R5: If DAT0 shows no token start within `timeout_i` cycles of entering the acknowledge wait, `ack_err_o` is set and `cmd_o` returns to 1.
- R6: With `ack_en_i`=0, the controller waits directly for a data start bit.
- R7: `bus_w_i` encodes the bus width: 0 = 1 line (DAT0), 1 = 4 lines (DAT3..DAT0), 2 = 8 lines. The value 3 acts as 1 line. A start bit is all used lines low, and unused lines are ignored. Payload is MSB first, so with 4 lines the high nibble comes first, and DAT3 carries the most significant bit of each nibble.
- R8: Each block carries 512 bytes. The 16 CRC cycles and the end bit that follow a block are consumed without checking. The controller then waits for the next block's start bit.
- R9: Every received byte appears on `byte_o` with `byte_vld_o` high for exactly one cycle, in arrival order.
- R10: A data start bit is accepted up to and including the `timeout_i`-th wait cycle. If it has not arrived after `timeout_i` wait cycles, `data_to_err_o` is set and `cmd_o` returns to 1.
- R11: After the end bit of the last block, `cmd_o` returns to 1 and `done_o` rises. `done_o` holds until the next start, and it never coincides with an error flag.
- R12: A `start_i` pulse with a block count of 0 sets `done_o` at once, and `cmd_o` never drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin boot read (accepted only while idle) |
| blk_cnt_i | input | CNT_W | Number of 512-byte blocks to read |
| bus_w_i | input | 2 | Bus width code |
| ack_en_i | input | 1 | Expect acknowledge token before data |
| timeout_i | input | TO_W | Wait limit in cycles for acknowledge or data start (must be at least 1) |
| dat_i | input | 8 | Raw data lines |
| cmd_o | output | 1 | CMD line level (0 = boot request held) |
| byte_o | output | 8 | Received byte |
| byte_vld_o | output | 1 | One-cycle strobe for `byte_o` |
| done_o | output | 1 | Boot read completed |
| ack_err_o | output | 1 | Acknowledge wrong or missing |
| data_to_err_o | output | 1 | Data start bit missing |

## Verification
The checker relies on the configuration inputs being stable whenever `start_i` is accepted. It also relies on `timeout_i` being at least one, and on `start_i` being pulsed only while the block is idle. The bench changes configuration only between runs and pulses `start_i` only after a previous run has ended with done or an error. It drives the data lines on the falling edge so that every value is stable across the sampling edge. It keeps unused lines at deliberately non-idle levels so that a width decode error would show up.

// File: rtl/mmc_boot_pkg.sv
package mmc_boot_pkg;
  typedef enum logic [1:0] {
    BW_1 = 2'd0,
    BW_4 = 2'd1,
    BW_8 = 2'd2
  } bus_w_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK_WAIT,
    ST_ACK_BITS,
    ST_DAT_WAIT,
    ST_DAT_RX,
    ST_TAIL
  } boot_st_e;
endpackage

// File: rtl/mbr_ctr.sv
module mbr_ctr #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/mbr_deser.sv
module mbr_deser
  import mmc_boot_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  bus_w_e     bw_i,
  input  logic [7:0] dat_i,
  output logic [7:0] byte_o,
  output logic       vld_o
);
  logic [7:0] sr_q, sr_d;
  logic [2:0] cnt_q, last;

  // units per byte minus one, MSB-first shift
  always_comb begin
    unique case (bw_i)
      BW_8: begin sr_d = dat_i;                   last = 3'd0; end
      BW_4: begin sr_d = {sr_q[3:0], dat_i[3:0]}; last = 3'd1; end
      default: begin sr_d = {sr_q[6:0], dat_i[0]}; last = 3'd7; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      byte_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (en_i) begin
        sr_q <= sr_d;
        if (cnt_q == last) begin
          cnt_q  <= '0;
          byte_o <= sr_d;
          vld_o  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mmc_boot_rd.sv
module mmc_boot_rd
  import mmc_boot_pkg::*;
#(
  parameter int BLK_BYTES = 512,
  parameter int CNT_W     = 8,
  parameter int TO_W      = 16,
  parameter int CRC_BITS  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] blk_cnt_i,
  input  logic [1:0]       bus_w_i,
  input  logic             ack_en_i,
  input  logic [TO_W-1:0]  timeout_i,
  input  logic [7:0]       dat_i,
  output logic             cmd_o,
  output logic [7:0]       byte_o,
  output logic             byte_vld_o,
  output logic             done_o,
  output logic             ack_err_o,
  output logic             data_to_err_o
);
  localparam int BIT_W = $clog2(BLK_BYTES * 8 + 1);
  localparam int CTR_W = (TO_W > BIT_W) ? TO_W : BIT_W;
  localparam logic [CTR_W-1:0] RX_1 = CTR_W'(BLK_BYTES * 8 - 1);
  localparam logic [CTR_W-1:0] RX_4 = CTR_W'(BLK_BYTES * 2 - 1);
  localparam logic [CTR_W-1:0] RX_8 = CTR_W'(BLK_BYTES - 1);
  localparam logic [CTR_W-1:0] TAIL_LAST = CTR_W'(CRC_BITS);

  boot_st_e         st_q, st_d;
  bus_w_e           bw_q;
  logic [TO_W-1:0]  to_q;
  logic [CNT_W-1:0] blk_left_q;
  logic [CTR_W-1:0] cnt;
  logic [CTR_W-1:0] rx_last_cnt;
  logic ctr_clr, go, finish, set_ack_err, set_dto, blk_dec;
  logic start_seen, wait_exp;

  mbr_ctr #(.W(CTR_W)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ctr_clr),
    .cnt_o (cnt)
  );

  mbr_deser u_deser (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (st_q != ST_DAT_RX),
    .en_i  (st_q == ST_DAT_RX),
    .bw_i  (bw_q),
    .dat_i (dat_i),
    .byte_o(byte_o),
    .vld_o (byte_vld_o)
  );

  always_comb begin
    unique case (bw_q)
      BW_8: begin start_seen = (dat_i == 8'h00);      rx_last_cnt = RX_8; end
      BW_4: begin start_seen = (dat_i[3:0] == 4'h0);  rx_last_cnt = RX_4; end
      default: begin start_seen = !dat_i[0];           rx_last_cnt = RX_1; end
    endcase
  end

  assign wait_exp = (cnt == CTR_W'(to_q - 1'b1));

  always_comb begin
    st_d        = st_q;
    ctr_clr     = 1'b0;
    go          = 1'b0;
    finish      = 1'b0;
    set_ack_err = 1'b0;
    set_dto     = 1'b0;
    blk_dec     = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        go      = 1'b1;
        ctr_clr = 1'b1;
        if (blk_cnt_i == '0) finish = 1'b1;
        else st_d = ack_en_i ? ST_ACK_WAIT : ST_DAT_WAIT;
      end
      ST_ACK_WAIT: begin
        if (!dat_i[0]) begin
          st_d    = ST_ACK_BITS;
          ctr_clr = 1'b1;
        end else if (wait_exp) begin
          set_ack_err = 1'b1;
          st_d        = ST_IDLE;
        end
      end
      ST_ACK_BITS: begin
        // expected sequence 0,1,0 then end bit 1 equals cnt[0]
        if (dat_i[0] != cnt[0]) begin
          set_ack_err = 1'b1;
          st_d        = ST_IDLE;
        end else if (cnt[1:0] == 2'd3) begin
          st_d    = ST_DAT_WAIT;
          ctr_clr = 1'b1;
        end
      end
      ST_DAT_WAIT: begin
        if (start_seen) begin
          st_d    = ST_DAT_RX;
          ctr_clr = 1'b1;
        end else if (wait_exp) begin
          set_dto = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      ST_DAT_RX: if (cnt == rx_last_cnt) begin
        st_d    = ST_TAIL;
        ctr_clr = 1'b1;
      end
      ST_TAIL: if (cnt == TAIL_LAST) begin
        ctr_clr = 1'b1;
        if (blk_left_q == CNT_W'(1)) begin
          finish = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          blk_dec = 1'b1;
          st_d    = ST_DAT_WAIT;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      bw_q          <= BW_1;
      to_q          <= '0;
      blk_left_q    <= '0;
      cmd_o         <= 1'b1;
      done_o        <= 1'b0;
      ack_err_o     <= 1'b0;
      data_to_err_o <= 1'b0;
    end else begin
      st_q <= st_d;
      if (go) begin
        bw_q          <= bus_w_e'(bus_w_i);
        to_q          <= timeout_i;
        blk_left_q    <= blk_cnt_i;
        ack_err_o     <= 1'b0;
        data_to_err_o <= 1'b0;
        done_o        <= finish;
        cmd_o         <= finish;
      end else begin
        if (finish) begin
          done_o <= 1'b1;
          cmd_o  <= 1'b1;
        end
        if (set_ack_err) begin
          ack_err_o <= 1'b1;
          cmd_o     <= 1'b1;
        end
        if (set_dto) begin
          data_to_err_o <= 1'b1;
          cmd_o         <= 1'b1;
        end
        if (blk_dec) blk_left_q <= blk_left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/mmc_boot_rd_chk.sv
module mmc_boot_rd_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic cmd_o,
  input logic byte_vld_o,
  input logic done_o,
  input logic ack_err_o,
  input logic data_to_err_o
);
  // R2
  cmd_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cmd_o) |-> $past(start_i));

  // R4
  ack_err_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_err_o |-> cmd_o);

  // R10
  dto_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_to_err_o |-> cmd_o);

  // R9
  vld_in_boot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> !cmd_o);

  // R11
  done_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cmd_o && !ack_err_o && !data_to_err_o));

  // R11
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(done_o) && !$past(start_i)) |-> done_o);
endmodule

bind mmc_boot_rd mmc_boot_rd_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .cmd_o        (cmd_o),
  .byte_vld_o   (byte_vld_o),
  .done_o       (done_o),
  .ack_err_o    (ack_err_o),
  .data_to_err_o(data_to_err_o)
);

// File: tb/mmc_boot_rd_tb_top.sv
module mmc_boot_rd_tb_top;
  localparam int BLK = 512;
  localparam int TO  = 20;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] blk_cnt_i = '0;
  logic [1:0] bus_w_i = '0;
  logic       ack_en_i = 1'b0;
  logic [15:0] timeout_i = 16'(TO);
  logic [7:0] dat_i = 8'hFF;
  logic       cmd_o, byte_vld_o, done_o, ack_err_o, data_to_err_o;
  logic [7:0] byte_o;

  int checks = 0;
  int failures = 0;
  int ngot = 0;
  logic [7:0] got [0:2047];
  bit fin = 1'b0;

  always #4 clk_i = ~clk_i;

  mmc_boot_rd dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .blk_cnt_i(blk_cnt_i),
    .bus_w_i(bus_w_i), .ack_en_i(ack_en_i), .timeout_i(timeout_i), .dat_i(dat_i),
    .cmd_o(cmd_o), .byte_o(byte_o), .byte_vld_o(byte_vld_o), .done_o(done_o),
    .ack_err_o(ack_err_o), .data_to_err_o(data_to_err_o)
  );

  always @(negedge clk_i) begin
    if (byte_vld_o && ngot < 2048) begin
      got[ngot] = byte_o;
      ngot++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int b, input int i);
    return 8'((b * 37 + i * 7 + 3) & 255);
  endfunction

  task automatic drv(input logic [7:0] v);
    dat_i = v;
    @(negedge clk_i);
  endtask

  task automatic pulse_start(input int nblk, input int w, input bit ack);
    blk_cnt_i = 8'(nblk);
    bus_w_i   = 2'(w);
    ack_en_i  = ack;
    ngot      = 0;
    start_i   = 1'b1;
    @(negedge clk_i);
    start_i   = 1'b0;
  endtask

  task automatic send_byte(input int w, input logic [7:0] b);
    if (w == 2) drv(b);
    else if (w == 1) begin
      drv({4'h5, b[7:4]});
      drv({4'h5, b[3:0]});
    end else begin
      for (int k = 7; k >= 0; k--) drv({7'h00, b[k]});
    end
  endtask

  task automatic send_ack();
    drv(8'hFF); drv(8'hFF);
    drv(8'hFE); drv(8'hFE); drv(8'hFF); drv(8'hFE); drv(8'hFF);
  endtask

  // R1
  task automatic t_reset();
    chk("R1 cmd", cmd_o, 1);
    chk("R1 vld", byte_vld_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 errs", {ack_err_o, data_to_err_o}, 0);
  endtask

  // R2 R3 R6 R7 R8 R9 R11
  task automatic t_boot(input int w, input bit ack, input int nblk, input int wcyc, input string tag);
    logic [7:0] idle_v, st_v;
    int bad;
    idle_v = (w == 2) ? 8'hFE : (w == 1) ? 8'h0F : 8'h01;
    st_v   = (w == 2) ? 8'h00 : (w == 1) ? 8'hF0 : 8'hFE;
    pulse_start(nblk, w, ack);
    chk({tag, " R2 cmd low"}, cmd_o, 0);
    chk({tag, " R2 done cleared"}, done_o, 0);
    if (ack) send_ack();
    for (int b = 0; b < nblk; b++) begin
      for (int c = 0; c < wcyc; c++) drv(idle_v);
      drv(st_v);
      for (int i = 0; i < BLK; i++) send_byte(w, pat(b, i));
      for (int t = 0; t < 17; t++) begin
        if (b == nblk - 1 && t == 16) chk({tag, " R2 cmd held"}, cmd_o, 0);
        drv(8'hFF);
      end
    end
    chk({tag, " R11 done"}, done_o, 1);
    chk({tag, " R11 cmd released"}, cmd_o, 1);
    chk({tag, " R3/R10 no err"}, {ack_err_o, data_to_err_o}, 0);
    chk({tag, " R8/R9 byte count"}, 32'(ngot), 32'(nblk * BLK));
    bad = -1;
    for (int i = 0; i < nblk * BLK && i < ngot; i++)
      if (bad < 0 && got[i] !== pat(i / BLK, i % BLK)) bad = i;
    if (bad >= 0) chk({tag, " R7/R9 byte value"}, got[bad], pat(bad / BLK, bad % BLK));
    else chk({tag, " R7/R9 byte values"}, 0, 0);
    repeat (3) drv(8'hFF);
    chk({tag, " R11 done held"}, done_o, 1);
  endtask

  // R4
  task automatic t_ack_bad();
    pulse_start(1, 2, 1'b1);
    drv(8'hFE); drv(8'hFE); drv(8'hFE);
    drv(8'hFF); drv(8'hFF);
    chk("R4 ack_err", ack_err_o, 1);
    chk("R4 cmd released", cmd_o, 1);
    for (int i = 0; i < 3; i++) drv(8'h00);
    chk("R4 no bytes", 32'(ngot), 0);
    chk("R4 no done", done_o, 0);
  endtask

  // R5
  task automatic t_ack_to();
    pulse_start(1, 2, 1'b1);
    for (int i = 0; i < TO - 1; i++) drv(8'hFF);
    chk("R5 no err before limit", ack_err_o, 0);
    drv(8'hFF);
    chk("R5 ack_err", ack_err_o, 1);
    chk("R5 cmd released", cmd_o, 1);
  endtask

  // R10
  task automatic t_data_to();
    pulse_start(1, 2, 1'b0);
    for (int i = 0; i < TO - 1; i++) drv(8'hFE);
    chk("R10 no err before limit", data_to_err_o, 0);
    drv(8'hFE);
    chk("R10 data_to_err", data_to_err_o, 1);
    chk("R10 cmd released", cmd_o, 1);
    chk("R10 no ack err", ack_err_o, 0);
  endtask

  // R12
  task automatic t_zero();
    pulse_start(0, 2, 1'b1);
    chk("R12 done", done_o, 1);
    chk("R12 cmd high", cmd_o, 1);
    repeat (4) drv(8'h00);
    chk("R12 no bytes", 32'(ngot), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!fin) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_boot(2, 1'b1, 2, 3, "w8_ack");
    t_boot(1, 1'b0, 1, 5, "w4_noack");
    t_boot(0, 1'b1, 1, 2, "w1_ack");
    t_boot(3, 1'b0, 1, 1, "w3_as_w1");
    t_boot(2, 1'b0, 1, TO - 1, "R10 edge");
    t_ack_bad();
    t_ack_to();
    t_data_to();
    t_zero();
    fin = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule